// File: doc/BRIEF.md
# TDM Time Slot Routing Sequencer

This block walks two small routing tables, one for the receive side and one for the transmit side, in step with a serial bit clock and a frame-sync pulse. Each table entry covers a run of bit slots or byte groups. For that run it chooses which channel port receives the incoming serial bit, or which channel supplies the outgoing bit. It also sets four framing strobe outputs. A per-entry swap bit exchanges the roles of the two serial data pins, so a second station can listen to, or answer over, the line that the first station drives.

Transmit and receive run from one common clock. A one-cycle `bit_en` marks the end of each bit slot. When `fsync` is high in a `bit_en` cycle, both tables restart at entry 0 for the slot that follows. A table is loaded through a small write port into a shadow copy. The shadow copy becomes the working copy at each frame sync, so a write made while a frame runs takes effect from the next frame.

Each entry is 14 bits wide:
- bits [2:0]: channel select
- bits [6:3]: count minus one
- bit 7: byte-unit flag
- bit 8: end-of-table flag
- bit 9: pin swap
- bits [13:10]: strobe values, with bit 10 driving strobe 0

Top module: `tdm_route_seq`

## Requirements
- R1: After reset, and before the first frame sync, all strobes are low, neither serial output is enabled, and no channel strobe or take pulse occurs.
- R2: A `bit_en` cycle with `fsync` high starts both tables at entry 0. Entry 0 governs the slot that begins at that clock edge.
- R3: An entry lasts (count+1) units. A unit is 1 slot, or 8 slots when the byte-unit flag (bit 7) is set.
- R4: While a receive entry with channel c in 1..N_CHAN governs the slot, `ch_rx_bit` carries the sampled pin, and `ch_rx_stb` bit c-1 pulses in the `bit_en` cycle that ends the slot. Channel 0 produces no pulse and a zero bit.
- R5: While a transmit entry with channel c in 1..N_CHAN governs the slot, the serial output carries `ch_tx_bit[c-1]` with its output enable high, and `ch_tx_take` bit c-1 pulses at the slot's `bit_en`. With channel 0, neither output enable is high.
- R6: With the swap bit (bit 9) set, a receive entry samples `txd_pin_i` instead of `rxd_pin_i`. A transmit entry with the swap bit set drives `rxd_o`/`rxd_oe` instead of `txd_o`/`txd_oe`. At most one output enable is ever high.
- R7: Strobe i follows bit 10+i of the entry currently in effect in the table chosen by `strb_dir[i]` (0 receive, 1 transmit). Several strobes may be high together.
- R8: Strobes change only at `bit_en` edges. A strobe set in two consecutive entries stays high across their boundary.
- R9: After the entry with the end-of-table flag finishes, or after entry 15 finishes, that table is idle: its strobes are low, it routes nothing, and it stays idle until the next frame sync.
- R10: Table writes (`wr_dir` 0 receive, 1 transmit) affect only frames started by a later frame sync. The frame in progress is unchanged.
- R11: A frame sync in the middle of a frame restarts both tables at entry 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse marking the end of a bit slot |
| fsync | input | 1 | Frame sync, sampled with bit_en |
| wr_en | input | 1 | Table write strobe |
| wr_dir | input | 1 | Table written: 0 receive, 1 transmit |
| wr_addr | input | 4 | Entry index written |
| wr_data | input | 14 | Entry contents |
| strb_dir | input | 4 | Table that owns each strobe: 0 receive, 1 transmit |
| rxd_pin_i | input | 1 | Level on the receive-data pin |
| txd_pin_i | input | 1 | Level on the transmit-data pin |
| txd_o | output | 1 | Data driven on the transmit-data pin |
| txd_oe | output | 1 | Output enable for the transmit-data pin |
| rxd_o | output | 1 | Data driven on the receive-data pin when swapped |
| rxd_oe | output | 1 | Output enable for the receive-data pin |
| ch_rx_bit | output | 1 | Received bit for the selected channel |
| ch_rx_stb | output | N_CHAN | Per-channel receive bit strobe |
| ch_tx_bit | input | N_CHAN | Next transmit bit from each channel |
| ch_tx_take | output | N_CHAN | Per-channel transmit bit consumed |
| strb_o | output | 4 | Framing strobes |

## Verification
The bench checks strobe boundaries most closely. A design that registered strobes from the old entry, or that dropped them between entries, would show a one-slot gap or lag. A design that kept driving after the end-of-table entry, or after entry 15, would leave strobes high or keep routing into the idle tail. Swapped entries are run with channel 0 and with live channels. This catches a wrong pin being sampled, the wrong output enable being raised, or a listen-only entry that still drives. Byte-unit entries are checked against bit-unit entries by counting channel pulses, which exposes an off-by-one in the unit counter. Writes made mid-frame and frame syncs made mid-frame check that the active table is latched only at frame sync.

// File: rtl/tdm_seq_pkg.sv
`timescale 1ns/1ps
package tdm_seq_pkg;
  localparam int CH_W      = 3;
  localparam int CNT_W     = 4;
  localparam int N_STRB    = 4;
  localparam int BYTE_BITS = 8;
  localparam int BIT_W     = $clog2(BYTE_BITS);

  // one routing entry; field order sets the write-port bit layout
  typedef struct packed {
    logic [N_STRB-1:0] strb;
    logic              swap;
    logic              last;
    logic              unit_byte;
    logic [CNT_W-1:0]  cnt;
    logic [CH_W-1:0]   chan;
  } route_ent_t;

  localparam int ENT_W = $bits(route_ent_t);
endpackage

// File: rtl/tdm_rst_sync.sv
`timescale 1ns/1ps
module tdm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/tdm_route_table.sv
`timescale 1ns/1ps
module tdm_route_table
  import tdm_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [AW-1:0] wr_addr,
  input  route_ent_t wr_ent,
  input  logic       commit,
  input  logic [AW-1:0] rd_addr,
  output route_ent_t rd_ent,
  output route_ent_t head_ent
);
  route_ent_t shd_q [DEPTH];
  route_ent_t act_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    route_ent_t shd_d, act_d;

    always_comb begin
      shd_d = shd_q[g];
      if (wr_en && wr_addr == AW'(g)) shd_d = wr_ent;
    end

    always_comb begin
      act_d = act_q[g];
      if (commit) act_d = shd_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_q[g] <= '0;
        act_q[g] <= '0;
      end else begin
        shd_q[g] <= shd_d;
        act_q[g] <= act_d;
      end
    end

    AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(act_q[g])); // R10
    AST_ACT_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> act_q[g] == $past(shd_q[g])); // R10
  end

  assign rd_ent   = act_q[rd_addr];
  assign head_ent = shd_q[0];
endmodule

// File: rtl/tdm_slot_seq.sv
`timescale 1ns/1ps
module tdm_slot_seq
  import tdm_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          fsync,
  input  route_ent_t    head_ent,
  input  route_ent_t    rd_ent,
  output logic [AW-1:0] rd_addr,
  output logic          run_q,
  output route_ent_t    cur_q,
  output logic          run_d,
  output route_ent_t    cur_d
);
  localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(BYTE_BITS - 1);
  localparam logic [AW-1:0]    IDX_TOP = AW'(DEPTH - 1);

  logic [AW-1:0]    idx_q, idx_d;
  logic [CNT_W-1:0] unit_q, unit_d;
  logic [BIT_W-1:0] bit_q, bit_d;

  assign rd_addr = idx_q + AW'(1);

  always_comb begin
    run_d  = run_q;
    idx_d  = idx_q;
    unit_d = unit_q;
    bit_d  = bit_q;
    cur_d  = cur_q;
    if (bit_en) begin
      if (fsync) begin
        run_d  = 1'b1;
        idx_d  = '0;
        cur_d  = head_ent;
        unit_d = head_ent.cnt;
        bit_d  = head_ent.unit_byte ? BIT_TOP : '0;
      end else if (run_q) begin
        if (bit_q != '0) begin
          bit_d = bit_q - BIT_W'(1);
        end else if (unit_q != '0) begin
          unit_d = unit_q - CNT_W'(1);
          bit_d  = cur_q.unit_byte ? BIT_TOP : '0;
        end else if (cur_q.last || idx_q == IDX_TOP) begin
          run_d = 1'b0;
        end else begin
          idx_d  = rd_addr;
          cur_d  = rd_ent;
          unit_d = rd_ent.cnt;
          bit_d  = rd_ent.unit_byte ? BIT_TOP : '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      unit_q <= '0;
      bit_q  <= '0;
      cur_q  <= '0;
    end else begin
      run_q  <= run_d;
      idx_q  <= idx_d;
      unit_q <= unit_d;
      bit_q  <= bit_d;
      cur_q  <= cur_d;
    end
  end

  AST_RESTART_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && fsync |=> run_q && idx_q == '0); // R2
  AST_HOLD_BETWEEN_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(idx_q) && $stable(run_q) && $stable(bit_q)); // R3
  AST_BIT_UNIT_NO_SUBCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !cur_q.unit_byte |-> bit_q == '0); // R3
  AST_STOP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && !fsync && run_q && bit_q == '0 && unit_q == '0 && cur_q.last |=> !run_q); // R9
  AST_NO_SELF_START: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !(bit_en && fsync) |=> !run_q); // R9
endmodule

// File: rtl/tdm_route_seq.sv
`timescale 1ns/1ps
module tdm_route_seq
  import tdm_seq_pkg::*;
#(
  parameter int N_CHAN = 7,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              fsync,
  input  logic              wr_en,
  input  logic              wr_dir,
  input  logic [3:0]        wr_addr,
  input  logic [13:0]       wr_data,
  input  logic [3:0]        strb_dir,
  input  logic              rxd_pin_i,
  input  logic              txd_pin_i,
  output logic              txd_o,
  output logic              txd_oe,
  output logic              rxd_o,
  output logic              rxd_oe,
  output logic              ch_rx_bit,
  output logic [N_CHAN-1:0] ch_rx_stb,
  input  logic [N_CHAN-1:0] ch_tx_bit,
  output logic [N_CHAN-1:0] ch_tx_take,
  output logic [3:0]        strb_o
);
  localparam int AW     = $clog2(DEPTH);
  localparam int N_DIR  = 2;
  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;

  logic rst_n_s;
  tdm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  route_ent_t    cur   [N_DIR];
  route_ent_t    nxt   [N_DIR];
  route_ent_t    rd_e  [N_DIR];
  route_ent_t    head  [N_DIR];
  logic [AW-1:0] rd_a  [N_DIR];
  logic          run   [N_DIR];
  logic          run_n [N_DIR];

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    tdm_route_table #(.DEPTH(DEPTH)) u_tbl (
      .clk(clk), .rst_n(rst_n_s),
      .wr_en(wr_en && (wr_dir == 1'(d))),
      .wr_addr(AW'(wr_addr)), .wr_ent(route_ent_t'(wr_data)),
      .commit(bit_en && fsync),
      .rd_addr(rd_a[d]), .rd_ent(rd_e[d]), .head_ent(head[d])
    );
    tdm_slot_seq #(.DEPTH(DEPTH)) u_seq (
      .clk(clk), .rst_n(rst_n_s), .bit_en(bit_en), .fsync(fsync),
      .head_ent(head[d]), .rd_ent(rd_e[d]), .rd_addr(rd_a[d]),
      .run_q(run[d]), .cur_q(cur[d]), .run_d(run_n[d]), .cur_d(nxt[d])
    );
  end

  // receive routing
  route_ent_t rxe, txe;
  logic       rx_ok, tx_ok, tx_bit;

  assign rxe   = cur[DIR_RX];
  assign txe   = cur[DIR_TX];
  assign rx_ok = run[DIR_RX] && rxe.chan != '0 && int'(rxe.chan) <= N_CHAN;
  assign tx_ok = run[DIR_TX] && txe.chan != '0 && int'(txe.chan) <= N_CHAN;

  assign ch_rx_bit = rx_ok ? (rxe.swap ? txd_pin_i : rxd_pin_i) : 1'b0;

  always_comb begin
    ch_rx_stb  = '0;
    ch_tx_take = '0;
    tx_bit     = 1'b0;
    for (int c = 0; c < N_CHAN; c++) begin
      if (rx_ok && rxe.chan == CH_W'(c + 1)) ch_rx_stb[c] = bit_en;
      if (tx_ok && txe.chan == CH_W'(c + 1)) begin
        ch_tx_take[c] = bit_en;
        tx_bit        = ch_tx_bit[c];
      end
    end
  end

  // transmit pin selection
  assign txd_oe = tx_ok && !txe.swap;
  assign rxd_oe = tx_ok && txe.swap;
  assign txd_o  = txd_oe & tx_bit;
  assign rxd_o  = rxd_oe & tx_bit;

  // strobes: registered from the next entry of the owning table
  logic [N_STRB-1:0] strb_q, strb_d;

  always_comb begin
    strb_d = strb_q;
    if (bit_en) begin
      for (int i = 0; i < N_STRB; i++) begin
        strb_d[i] = run_n[strb_dir[i]] && nxt[strb_dir[i]].strb[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) strb_q <= '0;
    else          strb_q <= strb_d;
  end

  assign strb_o = strb_q;

  AST_PIN_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({txd_oe, rxd_oe})); // R6
  AST_QUIET_NO_CHAN: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!run[DIR_TX] || txe.chan == '0) |-> !txd_oe && !rxd_oe && ch_tx_take == '0); // R5
  AST_RX_ONE_CHAN: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(ch_rx_stb)); // R4
  AST_STRB_STEADY: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bit_en |=> $stable(strb_o)); // R8
  AST_STRB_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !run[DIR_RX] && !run[DIR_TX] |-> strb_o == '0); // R9
endmodule

// File: tb/tdm_route_seq_tb.sv
`timescale 1ns/1ps
module tdm_route_seq_tb_top;
  import tdm_seq_pkg::*;

  localparam int N_CH = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, fsync = 1'b0;
  logic wr_en = 1'b0, wr_dir = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [13:0] wr_data = '0;
  logic [3:0]  strb_dir = '0;
  logic rxd_pin = 1'b0, txd_pin = 1'b0;
  logic txd_o, txd_oe, rxd_o, rxd_oe, ch_rx_bit;
  logic [N_CH-1:0] ch_rx_stb, ch_tx_take;
  logic [N_CH-1:0] ch_tx_bit = '0;
  logic [3:0] strb_o;

  always #10 clk = ~clk;

  tdm_route_seq #(.N_CHAN(N_CH), .DEPTH(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .wr_en(wr_en), .wr_dir(wr_dir), .wr_addr(wr_addr), .wr_data(wr_data),
    .strb_dir(strb_dir), .rxd_pin_i(rxd_pin), .txd_pin_i(txd_pin),
    .txd_o(txd_o), .txd_oe(txd_oe), .rxd_o(rxd_o), .rxd_oe(rxd_oe),
    .ch_rx_bit(ch_rx_bit), .ch_rx_stb(ch_rx_stb), .ch_tx_bit(ch_tx_bit),
    .ch_tx_take(ch_tx_take), .strb_o(strb_o)
  );

  int n_chk = 0, n_fail = 0;
  int k = -1;
  string ctx = "";
  route_ent_t m_shd [2][16];
  route_ent_t m_act [2][16];
  int cnt_rx [N_CH];
  int cnt_tx [N_CH];

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d (slot %0d)", req, ctx, what, act, exp, k);
    end
  endtask

  function automatic int ent_len(route_ent_t e);
    return (int'(e.cnt) + 1) * (e.unit_byte ? 8 : 1);
  endfunction

  // entry governing slot s of the active model table, or -1
  function automatic int model_idx(int d, int s);
    int pos = 0;
    if (s < 0) return -1;
    for (int e = 0; e < 16; e++) begin
      if (s < pos + ent_len(m_act[d][e])) return e;
      pos += ent_len(m_act[d][e]);
      if (m_act[d][e].last) break;
    end
    return -1;
  endfunction

  function automatic int shd_len(int d);
    int pos = 0;
    for (int e = 0; e < 16; e++) begin
      pos += ent_len(m_shd[d][e]);
      if (m_shd[d][e].last) break;
    end
    return pos;
  endfunction

  function automatic logic [3:0] exp_strb();
    logic [3:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      int d = int'(strb_dir[i]);
      int e = model_idx(d, k);
      if (e >= 0) r[i] = m_act[d][e].strb[i];
    end
    return r;
  endfunction

  task automatic wr(input int d, input int a, input route_ent_t e);
    @(negedge clk);
    wr_en = 1'b1; wr_dir = d[0]; wr_addr = a[3:0]; wr_data = e;
    @(negedge clk);
    wr_en = 1'b0;
    m_shd[d][a] = e;
  endtask

  function automatic route_ent_t mk(int ch, int cnt, bit by, bit last, bit sw, logic [3:0] st);
    route_ent_t e;
    e.chan = ch[2:0]; e.cnt = cnt[3:0]; e.unit_byte = by; e.last = last;
    e.swap = sw; e.strb = st;
    return e;
  endfunction

  task automatic check_slot();
    int e; route_ent_t ent; bit ok; string t;
    // receive side (R4, R6)
    e = model_idx(0, k); ok = 0; ent = '0;
    if (e >= 0) begin ent = m_act[0][e]; ok = ent.chan != 0; end
    t = (ok && ent.swap) ? "R6" : "R4";
    chk(t, "rx stb", int'(ch_rx_stb), ok ? (1 << (int'(ent.chan) - 1)) : 0);
    chk(t, "rx bit", int'(ch_rx_bit), ok ? int'(ent.swap ? txd_pin : rxd_pin) : 0);
    for (int c = 0; c < N_CH; c++) begin
      cnt_rx[c] += int'(ch_rx_stb[c]);
      cnt_tx[c] += int'(ch_tx_take[c]);
    end
    // transmit side (R5, R6)
    e = model_idx(1, k); ok = 0; ent = '0;
    if (e >= 0) begin ent = m_act[1][e]; ok = ent.chan != 0; end
    t = (ok && ent.swap) ? "R6" : "R5";
    chk(t, "txd_oe", int'(txd_oe), int'(ok && !ent.swap));
    chk(t, "rxd_oe", int'(rxd_oe), int'(ok && ent.swap));
    chk(t, "tx take", int'(ch_tx_take), ok ? (1 << (int'(ent.chan) - 1)) : 0);
    chk(t, "pin data", int'(txd_o | rxd_o), ok ? int'(ch_tx_bit[int'(ent.chan) - 1]) : 0);
    chk(k == 0 ? "R2" : (k < 0 ? "R9" : "R7"), "strobes", int'(strb_o), int'(exp_strb()));
  endtask

  task automatic do_slot(input bit fs);
    logic [3:0] first;
    @(negedge clk);
    bit_en = 1'b1; fsync = fs;
    rxd_pin = 1'($urandom); txd_pin = 1'($urandom); ch_tx_bit = N_CH'($urandom);
    #2 check_slot();
    @(negedge clk);
    bit_en = 1'b0; fsync = 1'b0;
    if (fs) begin
      for (int d = 0; d < 2; d++) for (int e = 0; e < 16; e++) m_act[d][e] = m_shd[d][e];
      k = 0;
    end else if (k >= 0) k++;
    first = strb_o;
    chk("R8", "strobes after edge", int'(first), int'(exp_strb()));
    repeat (2) @(negedge clk);
    chk("R8", "strobes held in slot", int'(strb_o), int'(first));
  endtask

  task automatic run_frame(input int n);
    do_slot(1'b1);
    for (int s = 1; s < n; s++) do_slot(1'b0);
  endtask

  task automatic clr_cnt();
    for (int c = 0; c < N_CH; c++) begin cnt_rx[c] = 0; cnt_tx[c] = 0; end
  endtask

  task automatic rand_tables();
    for (int d = 0; d < 2; d++) begin
      int n = 1 + int'($urandom % 6);
      for (int e = 0; e < 16; e++)
        wr(d, e, mk(int'($urandom % 8), int'($urandom % 4), ($urandom % 5) == 0,
                    e == n - 1, 1'($urandom), 4'($urandom)));
    end
  endtask

  initial begin
    #4ms;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    for (int d = 0; d < 2; d++) for (int e = 0; e < 16; e++) begin
      m_shd[d][e] = '0; m_act[d][e] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state and no activity before the first frame sync
    ctx = "R1";
    chk("R1", "strobes", int'(strb_o), 0);
    chk("R1", "oe", int'({txd_oe, rxd_oe}), 0);
    for (int s = 0; s < 4; s++) do_slot(1'b0);

    // directed frame: continuity, swap with chan 0 and live chans, byte units
    ctx = "R8";
    strb_dir = 4'b1100;
    wr(0, 0, mk(1, 2, 0, 0, 0, 4'b0001));
    wr(0, 1, mk(0, 1, 1, 0, 1, 4'b0001));
    wr(0, 2, mk(3, 0, 0, 1, 1, 4'b0011));
    wr(1, 0, mk(2, 0, 0, 0, 0, 4'b0100));
    wr(1, 1, mk(0, 2, 0, 0, 1, 4'b1100));
    wr(1, 2, mk(5, 1, 1, 0, 1, 4'b1100));
    wr(1, 3, mk(1, 0, 0, 1, 0, 4'b1000));
    clr_cnt();
    run_frame(24);
    chk("R3", "rx chan1 bit units", cnt_rx[0], 3);
    chk("R3", "rx chan3 pulses", cnt_rx[2], 1);
    chk("R3", "tx chan5 byte units", cnt_tx[4], 16);
    chk("R3", "tx chan2 pulses", cnt_tx[1], 1);

    // R10: write during a running frame, new contents only next frame
    ctx = "R10";
    do_slot(1'b1);
    do_slot(1'b0);
    wr(0, 0, mk(4, 0, 0, 1, 0, 4'b0010));
    wr(1, 0, mk(6, 3, 0, 1, 1, 4'b0100));
    for (int s = 0; s < 22; s++) do_slot(1'b0);
    run_frame(8);

    // R11: frame sync in the middle of a frame
    ctx = "R11";
    wr(0, 0, mk(2, 7, 1, 1, 0, 4'b0011));
    run_frame(5);
    run_frame(70);

    // R9: no end flag, entry 15 ends the table
    ctx = "R9";
    strb_dir = 4'b0001;
    for (int e = 0; e < 16; e++) wr(1, e, mk(7, 0, 0, 0, 0, 4'b0001));
    wr(0, 0, mk(0, 0, 0, 1, 0, 4'b0000));
    run_frame(20);

    // random frames, each run into its idle tail
    ctx = "rand";
    for (int f = 0; f < 8; f++) begin
      int len;
      strb_dir = 4'($urandom);
      rand_tables();
      len = shd_len(0) > shd_len(1) ? shd_len(0) : shd_len(1);
      run_frame(len + 3);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule